// File: doc/BRIEF.md
# Dual-Array Memory Mode Decoder

This block is a clocked front end for a memory part whose small read/write static array and much larger one-time-programmable (OTP) read-only array share one address bus and one 16-pin data bus. Each array has its own active-low select. The block turns the two selects, write strobe, output strobe and a width input into one operating mode. It then drives per-pin output enables for the shared data bus, and it raises a conflict flag when both arrays are selected at once.

In wide mode the bus carries a full 16-bit word. In narrow mode only pins 7..0 carry data and pins 14..8 float. Pin 15 becomes an input that carries the least significant byte-address bit. That bit picks one byte lane of the addressed word. Both arrays are small behavioural models with parameterised depth. The read/write array clears to zero on reset and the OTP array resets to all ones. Programming voltage and analog timing are not modelled. All outputs appear one clock after the inputs are sampled.

Top module: `dam_bus_front`

## Requirements
- R1: After reset, `bus_oe` is all zeros, `clash` is 0, and every static-array word reads back as 0.
- R2: With both selects high (standby), `bus_oe` is all zeros on the following cycle.
- R3: A static-array read happens when `otp_sel_n`=1, `ram_sel_n`=0, `wr_n`=1 and `rd_n`=0. In wide mode (`wide`=1), the next cycle has `bus_oe`=16'hFFFF and `bus_out` equal to the stored word. The word is indexed by the low RAM_AW bits of `addr`.
- R4: A static-array write happens when `otp_sel_n`=1, `ram_sel_n`=0 and `wr_n`=0, whatever the value of `rd_n`. In wide mode it stores `bus_in`, and on the next cycle `bus_oe` is all zeros.
- R5: With the static array selected, `wr_n`=1 and `rd_n`=1, nothing is driven: `bus_oe` is all zeros on the next cycle.
- R6: An OTP read happens when `otp_sel_n`=0, `ram_sel_n`=1 and `rd_n`=0. On the next cycle it returns all ones, with `bus_oe`=16'hFFFF in wide mode or 16'h00FF in narrow mode. With `rd_n`=1 the bus stays undriven.
- R7: When both selects are low, `clash` is 1 on the next cycle, `bus_oe` is all zeros, and no array word changes.
- R8: In narrow mode (`wide`=0), `bus_in[15]` selects the byte lane: 0 picks word bits 7..0 and 1 picks bits 15..8. A read drives `bus_oe`=16'h00FF and places the byte on `bus_out[7:0]`, with `bus_out[15:8]`=0.
- R9: A narrow-mode write stores `bus_in[7:0]` into the selected lane only. The other lane of that word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| otp_sel_n | input | 1 | OTP array select, active low |
| ram_sel_n | input | 1 | Static array select, active low |
| wr_n | input | 1 | Write strobe for the static array, active low |
| rd_n | input | 1 | Output strobe, active low |
| wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus with pin 15 as byte-address bit |
| addr | input | OTP_AW | Word address |
| bus_in | input | 16 | Values seen on the data pins |
| bus_out | output | 16 | Values the block drives onto the data pins |
| bus_oe | output | 16 | Per-pin drive enable, 1 = pin driven |
| clash | output | 1 | Both selects were low in the previous cycle |

## Verification
The assertions assume the inputs are stable for a whole clock period and change only between edges. They also assume the result of one cycle depends only on that cycle's control pins and never on a stored sequence. The stimulus drives every pin at the falling edge and compares at the next falling edge. This gives each sampled value a full cycle. The random phase draws all five control pins freely, so conflicts, standby and strobes without a select all occur. It keeps addresses inside the OTP range, and the static array sees the aliasing of the upper address bits.

// File: rtl/dam_pkg.sv
package dam_pkg;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_RAM_RD,
    MD_RAM_WR,
    MD_OTP_RD,
    MD_CLASH
  } md_e;

  localparam int BUS_W  = 16;
  localparam int LANE_N = 2;
  localparam int LANE_W = BUS_W / LANE_N;

endpackage

// File: rtl/dam_mode_dec.sv
module dam_mode_dec
  import dam_pkg::*;
(
  input  logic otp_sel_n,
  input  logic ram_sel_n,
  input  logic wr_n,
  input  logic rd_n,
  output md_e  mode
);

  always_comb begin
    mode = MD_IDLE;
    if (!otp_sel_n && !ram_sel_n)
      mode = MD_CLASH;
    else if (!ram_sel_n && !wr_n)
      mode = MD_RAM_WR;
    else if (!ram_sel_n && !rd_n)
      mode = MD_RAM_RD;
    else if (!otp_sel_n && !rd_n)
      mode = MD_OTP_RD;
  end

endmodule

// File: rtl/dam_ram_lane.sv
module dam_ram_lane #(
  parameter int AW = 6,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] wdata,
  output logic [LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/dam_otp_rom.sv
module dam_otp_rom #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      rdata <= '1;
    end else begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/dam_bus_front.sv
module dam_bus_front
  import dam_pkg::*;
#(
  parameter int RAM_AW = 6,
  parameter int OTP_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              otp_sel_n,
  input  logic              ram_sel_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              wide,
  input  logic [OTP_AW-1:0] addr,
  input  logic [15:0]       bus_in,
  output logic [15:0]       bus_out,
  output logic [15:0]       bus_oe,
  output logic              clash
);

  localparam logic [BUS_W-1:0] OE_WIDE   = '1;
  localparam logic [BUS_W-1:0] OE_NARROW = {{(BUS_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

  md_e mode;
  md_e mode_q;
  logic wide_q;
  logic pick_q;
  logic lane_pick;
  logic [BUS_W-1:0] ram_q;
  logic [BUS_W-1:0] otp_q;
  logic [BUS_W-1:0] src;

  assign lane_pick = bus_in[BUS_W-1];

  dam_mode_dec u_dec (
    .otp_sel_n (otp_sel_n),
    .ram_sel_n (ram_sel_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .mode      (mode)
  );

  for (genvar g = 0; g < LANE_N; g++) begin : g_lane
    logic          we_l;
    logic [LANE_W-1:0] wd_l;
    assign we_l = (mode == MD_RAM_WR) && (wide || (lane_pick == g[0]));
    assign wd_l = wide ? bus_in[g*LANE_W +: LANE_W] : bus_in[LANE_W-1:0];

    dam_ram_lane #(.AW(RAM_AW), .LW(LANE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .we    (we_l),
      .addr  (addr[RAM_AW-1:0]),
      .wdata (wd_l),
      .rdata (ram_q[g*LANE_W +: LANE_W])
    );
  end

  dam_otp_rom #(.AW(OTP_AW), .DW(BUS_W)) u_otp (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .rdata (otp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_IDLE;
      wide_q <= 1'b1;
      pick_q <= 1'b0;
      clash  <= 1'b0;
      bus_oe <= '0;
    end else begin
      mode_q <= mode;
      wide_q <= wide;
      pick_q <= lane_pick;
      clash  <= (mode == MD_CLASH);
      if (mode == MD_RAM_RD || mode == MD_OTP_RD)
        bus_oe <= wide ? OE_WIDE : OE_NARROW;
      else
        bus_oe <= '0;
    end
  end

  always_comb begin
    src = (mode_q == MD_OTP_RD) ? otp_q : ram_q;
    if (wide_q)
      bus_out = src;
    else
      bus_out = {{(BUS_W-LANE_W){1'b0}},
                 pick_q ? src[BUS_W-1 -: LANE_W] : src[LANE_W-1:0]};
  end

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (otp_sel_n && ram_sel_n) |=> (bus_oe == '0));                 // R2
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (otp_sel_n && !ram_sel_n && !wr_n) |=> (bus_oe == '0));       // R4
  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!otp_sel_n && !ram_sel_n) |=> clash);                        // R7
  AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (rst)
    clash |-> (bus_oe == '0));                                    // R7
  AST_NARROW_UPPER_FLOAT: assert property (@(posedge clk) disable iff (rst)
    !wide |=> (bus_oe[BUS_W-1:LANE_W] == '0));                    // R8
  AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rd_n && ram_sel_n == 1'b0 && otp_sel_n && wr_n) |=> (bus_oe == '0)); // R5

endmodule

// File: tb/test_dam_bus_front.sv
module test_dam_bus_front;

  localparam int RAM_AW = 6;
  localparam int OTP_AW = 8;
  localparam int RDEPTH = 1 << RAM_AW;

  logic clk = 1'b0;
  logic rst;
  logic otp_sel_n, ram_sel_n, wr_n, rd_n, wide;
  logic [OTP_AW-1:0] addr;
  logic [15:0] bus_in, bus_out, bus_oe;
  logic clash;

  int total = 0;
  int bad = 0;
  logic [15:0] ref_ram [RDEPTH];

  always #10 clk = ~clk;

  dam_bus_front #(.RAM_AW(RAM_AW), .OTP_AW(OTP_AW)) i_dam_bus_front (
    .clk(clk), .rst(rst), .otp_sel_n(otp_sel_n), .ram_sel_n(ram_sel_n),
    .wr_n(wr_n), .rd_n(rd_n), .wide(wide), .addr(addr), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .clash(clash)
  );

  // Drive one cycle, update reference model, check at the following falling edge.
  task automatic step(input logic o_n, input logic r_n, input logic w_n,
                      input logic d_n, input logic wd, input logic [OTP_AW-1:0] a,
                      input logic [15:0] din, input string tag_in);
    logic [15:0] e_oe, e_out;
    logic e_clash;
    logic [RAM_AW-1:0] ra;
    string tag;
    tag = tag_in;
    ra = a[RAM_AW-1:0];
    e_oe = 16'h0; e_out = 16'h0; e_clash = 1'b0;
    otp_sel_n = o_n; ram_sel_n = r_n; wr_n = w_n; rd_n = d_n; wide = wd;
    addr = a; bus_in = din;
    if (!o_n && !r_n) begin
      e_clash = 1'b1;
      if (tag == "") tag = "R7";
    end else if (!r_n && !w_n) begin
      if (wd) ref_ram[ra] = din;
      else if (din[15]) ref_ram[ra][15:8] = din[7:0];
      else ref_ram[ra][7:0] = din[7:0];
      if (tag == "") tag = wd ? "R4" : "R9";
    end else if (!r_n && !d_n) begin
      e_oe = wd ? 16'hFFFF : 16'h00FF;
      e_out = wd ? ref_ram[ra] : {8'h00, din[15] ? ref_ram[ra][15:8] : ref_ram[ra][7:0]};
      if (tag == "") tag = wd ? "R3" : "R8";
    end else if (!o_n && !d_n) begin
      e_oe = wd ? 16'hFFFF : 16'h00FF;
      e_out = wd ? 16'hFFFF : 16'h00FF;
      if (tag == "") tag = "R6";
    end else begin
      if (tag == "") tag = (o_n && r_n) ? "R2" : (!r_n ? "R5" : "R6");
    end
    @(negedge clk);
    total++;
    if (bus_oe !== e_oe || clash !== e_clash || (e_oe != 16'h0 && bus_out !== e_out)) begin
      bad++;
      $display("FAIL %s: oe=%h out=%h clash=%b expected oe=%h out=%h clash=%b",
               tag, bus_oe, bus_out, clash, e_oe, e_out, e_clash);
    end
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < RDEPTH; i++) ref_ram[i] = 16'h0;
    rst = 1'b1;
    otp_sel_n = 1'b1; ram_sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; wide = 1'b1;
    addr = '0; bus_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    total++;
    if (bus_oe !== 16'h0 || clash !== 1'b0) begin
      bad++;
      $display("FAIL R1: oe=%h clash=%b expected oe=0000 clash=0", bus_oe, clash);
    end
    rst = 1'b0;
    step(1, 0, 1, 0, 1, 8'h05, 16'h0, "R1");          // R1: cleared word reads 0
    step(1, 1, 1, 1, 1, 8'h05, 16'h0, "R2");          // R2 standby
    step(1, 0, 0, 0, 1, 8'h05, 16'hA55A, "R4");       // R4 write with rd_n low
    step(1, 0, 1, 0, 1, 8'h05, 16'h0, "R3");          // R3 read back
    step(1, 0, 1, 0, 1, 8'h45, 16'h0, "R3");          // R3 aliased upper addr bits
    step(1, 0, 1, 1, 1, 8'h05, 16'h0, "R5");          // R5 no strobe
    step(1, 0, 0, 1, 0, 8'h05, 16'h8033, "R9");       // R9 write high lane
    step(1, 0, 1, 0, 1, 8'h05, 16'h0, "R9");          // expect 335A
    step(1, 0, 1, 0, 0, 8'h05, 16'h0000, "R8");       // R8 low lane
    step(1, 0, 1, 0, 0, 8'h05, 16'h8000, "R8");       // R8 high lane
    step(0, 0, 0, 0, 1, 8'h05, 16'h1111, "R7");       // R7 clash, no write
    step(1, 0, 1, 0, 1, 8'h05, 16'h0, "R7");          // still 335A
    step(0, 1, 1, 0, 1, 8'hC3, 16'h0, "R6");          // R6 wide
    step(0, 1, 1, 0, 0, 8'hC3, 16'h8000, "R6");       // R6 narrow
    step(0, 1, 1, 1, 1, 8'hC3, 16'h0, "R6");          // R6 rd_n high
    for (int n = 0; n < 600; n++) begin
      step($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
           OTP_AW'($urandom), 16'($urandom), "");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule